// File: doc/BRIEF.md
# Multiply-Accumulate Instruction Unit with Local Register Bank

This block is a multi-cycle instruction unit that sits beside a processor pipeline. Each instruction multiplies two operands and adds the product into a running accumulator. Per operand, a flag picks the source. The value can come from the processor's operand bus, or it can be read from a bank of 32 local registers that belongs to the unit.

A third flag sets where the sum goes. When the flag is low, the sum stays in the unit: the accumulator keeps it and a copy is written into the local register named by the destination index. When the flag is high, the sum is handed to the processor on the result bus and the accumulator restarts from zero, ready for a new series.

An instruction begins with a one-cycle start pulse. It completes two enabled clock edges later with a one-cycle done pulse. The clock-enable input freezes all state while it is low.

Top module: `mac_regfile_unit`

## Requirements
- R1: When `a_from_host` is 1 at the start edge, the first factor is `opnd_a`; when it is 0, the first factor is local register number `src_a_idx` (index values 0 to 31 select registers 0 to 31).
- R2: When `b_from_host` is 1 at the start edge, the second factor is `opnd_b`; when it is 0, the second factor is local register number `src_b_idx`.
- R3: The product keeps only its low 32 bits, and the sum (accumulator + product) wraps modulo 2^32.
- R4: When `ret_to_host` is 0, the sum becomes the new accumulator value and is also written into local register `dst_idx`.
- R5: When `ret_to_host` is 1, `res` carries the sum, the accumulator returns to 0 for the next instruction, and no local register changes.
- R6: `done` is 1 for exactly one enabled cycle. That cycle follows the second enabled rising edge at or after the edge that samples `start`, and `res` holds the sum while `done` is 1.
- R7: While `clk_en` is 0, no state changes: `done`, `res`, the accumulator and the local registers all hold.
- R8: `reset` (active high) clears the accumulator, all 32 local registers, `done` and `res` to 0.
- R9: Registers 0 and 31 are separately addressable; a write to one leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clk_en | input | 1 | Clock qualifier; all state holds while low |
| reset | input | 1 | Active-high reset of all state |
| start | input | 1 | One-cycle pulse that launches an instruction |
| done | output | 1 | One-cycle pulse marking a valid `res` |
| opnd_a | input | 32 | First factor from the processor |
| opnd_b | input | 32 | Second factor from the processor |
| res | output | 32 | Sum returned to the processor |
| src_a_idx | input | 5 | Local register index for the first factor |
| src_b_idx | input | 5 | Local register index for the second factor |
| dst_idx | input | 5 | Local register index written when the sum is kept |
| a_from_host | input | 1 | 1: first factor from `opnd_a`; 0: from local register |
| b_from_host | input | 1 | 1: second factor from `opnd_b`; 0: from local register |
| ret_to_host | input | 1 | 1: return sum and clear accumulator; 0: keep sum locally |

## Verification
The bench drives a long mix of instructions with random sources, indices and operand values against a model of the accumulator and register bank. A swapped or inverted source select would return host data where a local value was expected. A missed writeback, or a returned sum that fails to clear the accumulator, would corrupt every later result in the series. Directed cases cover:
- clock-enable stalls both in flight and while `done` is high; a design that ignores the qualifier would drop or stretch the pulse;
- products that overflow 32 bits;
- the extreme register indices 0 and 31, where an address decode error would alias the two;
- a readback of cleared registers after reset.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // Default geometry of the unit
    localparam int unsigned MAC_DATA_W = 32;
    localparam int unsigned MAC_IDX_W  = 5;

    // Operand source encoding on the select flags
    typedef enum logic {
        SRC_LOCAL = 1'b0,
        SRC_HOST  = 1'b1
    } src_sel_e;

endpackage

// File: rtl/mac_lreg_bank.sv
module mac_lreg_bank #(
    parameter int unsigned DATA_W = mac_pkg::MAC_DATA_W,
    parameter int unsigned IDX_W  = mac_pkg::MAC_IDX_W
) (
    input  logic              clk,
    input  logic              clk_en,
    input  logic              reset,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_data_b
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] entry_q [DEPTH];

    // One storage word per index; each word has its own decode
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [DATA_W-1:0] entry_d;
        logic              hit;

        always_comb begin
            hit     = wr_en && (wr_idx == IDX_W'(g));
            entry_d = hit ? wr_data : entry_q[g];
        end

        always_ff @(posedge clk) begin
            if (reset) begin
                entry_q[g] <= '0;
            end else if (clk_en) begin
                entry_q[g] <= entry_d;
            end
        end
    end

    // Asynchronous read ports
    always_comb begin
        rd_data_a = entry_q[rd_idx_a];
        rd_data_b = entry_q[rd_idx_b];
    end

endmodule

// File: rtl/mac_opnd_sel.sv
module mac_opnd_sel #(
    parameter int unsigned DATA_W = mac_pkg::MAC_DATA_W
) (
    input  mac_pkg::src_sel_e sel,
    input  logic [DATA_W-1:0] host_val,
    input  logic [DATA_W-1:0] local_val,
    output logic [DATA_W-1:0] opnd
);
    always_comb begin
        unique case (sel)
            mac_pkg::SRC_HOST:  opnd = host_val;
            mac_pkg::SRC_LOCAL: opnd = local_val;
            default:            opnd = local_val;
        endcase
    end
endmodule

// File: rtl/mac_mul_trunc.sv
module mac_mul_trunc #(
    parameter int unsigned DATA_W = mac_pkg::MAC_DATA_W
) (
    input  logic [DATA_W-1:0] fa,
    input  logic [DATA_W-1:0] fb,
    output logic [DATA_W-1:0] prod_lo
);
    localparam int unsigned FULL_W = 2 * DATA_W;

    logic [FULL_W-1:0] full;

    always_comb begin
        full    = FULL_W'(fa) * FULL_W'(fb);
        prod_lo = full[DATA_W-1:0];
    end
endmodule

// File: rtl/mac_regfile_unit.sv
module mac_regfile_unit #(
    parameter int unsigned DATA_W = mac_pkg::MAC_DATA_W,
    parameter int unsigned IDX_W  = mac_pkg::MAC_IDX_W
) (
    input  logic              clk,
    input  logic              clk_en,
    input  logic              reset,
    input  logic              start,
    output logic              done,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] res,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic              a_from_host,
    input  logic              b_from_host,
    input  logic              ret_to_host
);
    localparam int unsigned NUM_SRC = 2;

    typedef struct packed {
        logic              busy;
        logic              ret;
        logic [IDX_W-1:0]  dst;
        logic [DATA_W-1:0] prod;
        logic [DATA_W-1:0] acc;
        logic              done;
        logic [DATA_W-1:0] res;
    } mac_state_t;

    mac_state_t st_d, st_q;

    logic [DATA_W-1:0] host_val  [NUM_SRC];
    logic [DATA_W-1:0] local_val [NUM_SRC];
    logic [DATA_W-1:0] factor    [NUM_SRC];
    mac_pkg::src_sel_e sel_val   [NUM_SRC];

    logic [DATA_W-1:0] prod_d;
    logic [DATA_W-1:0] sum_d;
    logic              wr_en_d;

    always_comb begin
        host_val[0] = opnd_a;
        host_val[1] = opnd_b;
        sel_val[0]  = mac_pkg::src_sel_e'(a_from_host);
        sel_val[1]  = mac_pkg::src_sel_e'(b_from_host);
    end

    mac_lreg_bank #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk       (clk),
        .clk_en    (clk_en),
        .reset     (reset),
        .wr_en     (wr_en_d),
        .wr_idx    (st_q.dst),
        .wr_data   (sum_d),
        .rd_idx_a  (src_a_idx),
        .rd_data_a (local_val[0]),
        .rd_idx_b  (src_b_idx),
        .rd_data_b (local_val[1])
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        mac_opnd_sel #(
            .DATA_W (DATA_W)
        ) u_sel (
            .sel       (sel_val[s]),
            .host_val  (host_val[s]),
            .local_val (local_val[s]),
            .opnd      (factor[s])
        );
    end

    mac_mul_trunc #(
        .DATA_W (DATA_W)
    ) u_mul (
        .fa      (factor[0]),
        .fb      (factor[1]),
        .prod_lo (prod_d)
    );

    // Next-state computation: stage one captures the product,
    // stage two accumulates and retires
    always_comb begin
        st_d    = st_q;
        sum_d   = st_q.acc + st_q.prod;
        wr_en_d = 1'b0;
        st_d.done = 1'b0;

        if (st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.res  = sum_d;
            if (st_q.ret) begin
                st_d.acc = '0;
            end else begin
                st_d.acc = sum_d;
                wr_en_d  = 1'b1;
            end
        end

        if (start && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.prod = prod_d;
            st_d.ret  = ret_to_host;
            st_d.dst  = dst_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (reset) begin
            st_q <= '0;
        end else if (clk_en) begin
            st_q <= st_d;
        end
    end

    assign done = st_q.done;
    assign res  = st_q.res;

endmodule

// File: rtl/mac_regfile_unit_chk.sv
module mac_regfile_unit_chk #(
    parameter int unsigned DATA_W = mac_pkg::MAC_DATA_W
) (
    input logic              clk,
    input logic              clk_en,
    input logic              reset,
    input logic              start,
    input logic              done,
    input logic [DATA_W-1:0] res
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (reset) begin
            pend_q <= 1'b0;
        end else if (clk_en) begin
            pend_q <= start && !pend_q;
        end
    end

    // R6
    done_after_two_chk: assert property (@(posedge clk) disable iff (reset)
        (clk_en && pend_q) |=> done);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (reset)
        (clk_en && done) |=> !done);

    // R6
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (reset)
        (clk_en && !pend_q) |=> !done);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (reset)
        !clk_en |=> ($stable(done) && $stable(res)));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        reset |=> (!done && res == '0));

endmodule

bind mac_regfile_unit mac_regfile_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .clk_en (clk_en),
    .reset  (reset),
    .start  (start),
    .done   (done),
    .res    (res)
);

// File: tb/tb_mac_regfile_unit.sv
module tb_mac_regfile_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        clk_en, reset, start;
    logic        done;
    logic [31:0] opnd_a, opnd_b, res;
    logic [4:0]  src_a_idx, src_b_idx, dst_idx;
    logic        a_from_host, b_from_host, ret_to_host;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [31:0] m_rf [32];
    logic [31:0] m_acc;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_regfile_unit dut (
        .clk(clk), .clk_en(clk_en), .reset(reset), .start(start), .done(done),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res(res),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .dst_idx(dst_idx),
        .a_from_host(a_from_host), .b_from_host(b_from_host), .ret_to_host(ret_to_host)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] pick(input bit host, input logic [31:0] hv,
                                         input logic [4:0] idx);
        return host ? hv : m_rf[idx];
    endfunction

    // One instruction; optional stalls in flight and during done
    task automatic do_op(input bit ah, input bit bh, input bit rt,
                         input logic [4:0] ia, input logic [4:0] ib, input logic [4:0] ic,
                         input logic [31:0] da, input logic [31:0] db,
                         input bit stall, input string tag);
        logic [31:0] prod, sum;
        prod = pick(ah, da, ia) * pick(bh, db, ib);
        sum  = m_acc + prod;
        @(negedge clk);
        a_from_host = ah; b_from_host = bh; ret_to_host = rt;
        src_a_idx = ia; src_b_idx = ib; dst_idx = ic;
        opnd_a = da; opnd_b = db; start = 1'b1; clk_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R6 done early", {31'b0, done}, 32'd0);
        if (stall) begin
            clk_en = 1'b0;
            repeat (3) @(negedge clk);
            check(done == 1'b0, "R7 stall in flight", {31'b0, done}, 32'd0);
            clk_en = 1'b1;
        end
        @(negedge clk);
        check(done == 1'b1, "R6 done", {31'b0, done}, 32'd1);
        check(res == sum, tag, res, sum);
        if (stall) begin
            clk_en = 1'b0;
            repeat (2) @(negedge clk);
            check(done == 1'b1 && res == sum, "R7 stall at done", res, sum);
            clk_en = 1'b1;
        end
        @(negedge clk);
        check(done == 1'b0, "R6 single pulse", {31'b0, done}, 32'd0);
        if (rt) m_acc = '0;
        else begin
            m_acc = sum;
            m_rf[ic] = sum;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        clk_en = 1'b1; reset = 1'b1; start = 1'b0;
        opnd_a = '0; opnd_b = '0; src_a_idx = '0; src_b_idx = '0; dst_idx = '0;
        a_from_host = 1'b1; b_from_host = 1'b1; ret_to_host = 1'b1;
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        m_acc = '0;
        repeat (3) @(negedge clk);
        reset = 1'b0;
        check(done == 1'b0 && res == '0, "R8 reset outputs", res, 32'd0);

        // R8: cleared register read back (local A times host 1, returned)
        do_op(0, 1, 1, 5'd31, 5'd0, 5'd0, 32'h0, 32'd1, 0, "R8 reg31 cleared");
        // R3: overflowing product, returned
        do_op(1, 1, 1, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3 wrap product");
        // R4: keep locally into reg 0 and reg 31
        do_op(1, 1, 0, 0, 0, 5'd0, 32'd7, 32'd6, 0, "R4 keep reg0");
        do_op(1, 1, 0, 0, 0, 5'd31, 32'h8000_0000, 32'd3, 1, "R4 keep reg31 with stall");
        // R5: return clears accumulator
        do_op(1, 1, 1, 0, 0, 0, 32'd1, 32'd1, 0, "R5 return sum");
        do_op(1, 1, 1, 0, 0, 0, 32'd2, 32'd3, 0, "R5 acc cleared");
        // R9: registers 0 and 31 distinct
        do_op(0, 1, 1, 5'd0, 0, 0, 32'd0, 32'd1, 0, "R9 reg0 value");
        do_op(0, 1, 1, 5'd31, 0, 0, 32'd0, 32'd1, 0, "R9 reg31 value");
        // R1 / R2: local factors on each side
        do_op(0, 1, 1, 5'd0, 0, 0, 32'd0, 32'd5, 0, "R1 local A");
        do_op(1, 0, 1, 0, 5'd31, 0, 32'd9, 32'hDEAD, 0, "R2 local B");
        do_op(0, 0, 1, 5'd31, 5'd0, 0, 32'hAAAA, 32'h5555, 0, "R1 R2 both local");

        for (int k = 0; k < 400; k++) begin
            do_op($urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 3) == 0),
                  5'($urandom), 5'($urandom), 5'($urandom), $urandom, $urandom,
                  ($urandom_range(0, 7) == 0), "R4 R5 random series");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule